// File: doc/BRIEF.md
# Fractional Synthesizer Parameter Search Engine

This block works out the programming codes for a fractional frequency synthesizer channel. Given a reference frequency and a wanted output frequency, it finds the output divider exponent, the coarse divider and the 15-bit phase step that bring the achieved rate closest to the target. It reports the achieved rate with the codes, or flags that no code set exists.

The achieved rate is `fin * 2^25 / ((2^20 * (32 + md) + 32 * pe) * 2^sdiv)`. The divide-by-3 stage is held in bypass during the search, so the ns factor is 1. For each divider pair the phase step comes straight from that equation, rounded down. All candidate evaluation runs through one shared sequential restoring divider. A search therefore takes thousands of cycles, and how many depends on the data.

A controller pulses `i_start` with both frequencies held on the inputs. It then waits for the one-cycle `o_done` pulse and reads the result ports, which hold until the next search completes.

Top module: `fsyn_param_search`

## Requirements
- R1: For a reported solution, `o_rate` equals floor(fin·2^25 / ((2^20·(32+o_md) + 32·o_pe)·2^o_sdiv)).
- R2: For a candidate (sdiv, md), the phase step is floor((fin·2^20 − (32+md)·(fout·2^sdiv)·2^15) / (fout·2^sdiv)). The candidate is valid only if the numerator is non-negative and the quotient is at most 32767.
- R3: sdiv is visited from 0 up to 8. For each sdiv, md = 0 and then md = 31 are tried first. If both are valid and the phase step for md = 0 exceeds the one for md = 31, the rest of that sdiv is skipped. Otherwise md is visited from 1 to 30. A candidate replaces the best one only on a strictly smaller absolute deviation |fout − rate|, which starts at all ones.
- R4: As soon as the best deviation is zero the search ends, and the first exact candidate is reported.
- R5: When the sweep ends with a nonzero deviation, phase steps from best−2 to best+2 (clamped to 0..32767) are tried at the best sdiv and md. The one with strictly smaller deviation is kept.
- R6: If no valid candidate exists, or either input frequency is zero, `o_nosol` is 1 and the codes and rate are 0.
- R7: `o_done` is a single-cycle pulse. `o_busy` rises the cycle after an accepted start and falls as `o_done` rises. A start while busy is ignored.
- R8: Result ports change only in the cycle `o_done` is high.
- R9: After reset, `o_busy`, `o_done`, `o_nosol`, the codes and the rate are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock |
| i_rst | input | 1 | Synchronous active-high reset |
| i_start | input | 1 | Start pulse, sampled while idle |
| i_fin | input | FW | Reference frequency |
| i_fout | input | FW | Target output frequency |
| o_busy | output | 1 | Search in progress |
| o_done | output | 1 | One-cycle completion pulse |
| o_nosol | output | 1 | No valid code set found |
| o_sdiv | output | 4 | Output divider exponent |
| o_md | output | 5 | Coarse divider code |
| o_pe | output | 15 | Phase step code |
| o_rate | output | FW | Achieved output rate |

## Verification
The search length depends on the data, so no result has a fixed cycle offset from the start. What is fixed is that every result port is valid in the same cycle as the `o_done` pulse, one register after the final state. The bench drives inputs on falling edges and waits for `o_done` on falling edges. It compares all result ports in that cycle against an independent model of the search. It checks again some cycles later, to confirm the ports have held.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
  localparam int SDIV_LAST = 8;
  localparam int MD_TOP    = 31;
  localparam int PE_W      = 15;

  typedef enum logic [2:0] {
    S_IDLE, S_PE_GO, S_PE_WAIT, S_RT_GO, S_RT_WAIT, S_NEXT, S_DONE
  } state_t;

  typedef enum logic [1:0] {
    PH_LO, PH_HI, PH_SWEEP, PH_TUNE
  } phase_t;
endpackage

// File: rtl/fsyn_divider.sv
module fsyn_divider #(
  parameter int W = 57
) (
  input  logic         i_clk,
  input  logic         i_rst,
  input  logic         i_go,
  input  logic [W-1:0] i_num,
  input  logic [W-1:0] i_den,
  output logic [W-1:0] o_quo,
  output logic         o_done
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem, rem_sh, diff;
  logic [W-1:0]  den_r;
  logic [CW-1:0] cnt;
  logic          run, ge;

  always_comb begin
    rem_sh = {rem[W-1:0], o_quo[W-1]};
    ge     = rem_sh >= {1'b0, den_r};
    diff   = rem_sh - {1'b0, den_r};
  end

  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      rem    <= '0;
      den_r  <= '0;
      o_quo  <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      o_done <= 1'b0;
    end else begin
      o_done <= 1'b0;
      if (i_go) begin
        rem   <= '0;
        den_r <= i_den;
        o_quo <= i_num;
        cnt   <= CW'(W);
        run   <= 1'b1;
      end else if (run) begin
        rem   <= ge ? diff : rem_sh;
        o_quo <= {o_quo[W-2:0], ge};
        cnt   <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run    <= 1'b0;
          o_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsyn_terms.sv
module fsyn_terms #(
  parameter int FW = 32,
  parameter int DW = FW + 25
) (
  input  logic [FW-1:0] i_fin,
  input  logic [FW-1:0] i_fout,
  input  logic [3:0]    i_si,
  input  logic [4:0]    i_md,
  input  logic [14:0]   i_pe,
  output logic [DW-1:0] o_pe_num,
  output logic [DW-1:0] o_pe_den,
  output logic          o_pe_neg,
  output logic [DW-1:0] o_rt_num,
  output logic [DW-1:0] o_rt_den
);
  localparam int TW = FW + 30;

  logic [TW-1:0] fin_big, fout_sh, sub_term;

  always_comb begin
    fin_big  = TW'(i_fin) << 20;
    fout_sh  = TW'(i_fout) << i_si;
    sub_term = ((TW'(i_md) + TW'(32)) * fout_sh) << 15;
    o_pe_neg = sub_term > fin_big;
    o_pe_num = DW'(fin_big - sub_term);
    o_pe_den = DW'(fout_sh);
    o_rt_num = DW'(i_fin) << 25;
    o_rt_den = (((DW'(i_md) + DW'(32)) << 20) + (DW'(i_pe) << 5)) << i_si;
  end
endmodule

// File: rtl/fsyn_param_search.sv
module fsyn_param_search
  import fsyn_pkg::*;
#(
  parameter int FW = 32
) (
  input  logic          i_clk,
  input  logic          i_rst,
  input  logic          i_start,
  input  logic [FW-1:0] i_fin,
  input  logic [FW-1:0] i_fout,
  output logic          o_busy,
  output logic          o_done,
  output logic          o_nosol,
  output logic [3:0]    o_sdiv,
  output logic [4:0]    o_md,
  output logic [14:0]   o_pe,
  output logic [FW-1:0] o_rate
);
  localparam int DW = FW + 25;

  state_t state;
  phase_t phase;

  logic [FW-1:0] fin_r, fout_r, best_rate, best_dev, cur_rate, cur_dev;
  logic [3:0]    si, best_si;
  logic [4:0]    md, best_md;
  logic [14:0]   pe_c, lo_pe, best_pe, tune_hi;
  logic          cand_ok, lo_ok, found;

  logic [DW-1:0] pe_num, pe_den, rt_num, rt_den, div_num, div_den, div_q;
  logic          pe_neg, div_go, div_done;

  fsyn_terms #(.FW(FW), .DW(DW)) u_terms (
    .i_fin(fin_r), .i_fout(fout_r), .i_si(si), .i_md(md), .i_pe(pe_c),
    .o_pe_num(pe_num), .o_pe_den(pe_den), .o_pe_neg(pe_neg),
    .o_rt_num(rt_num), .o_rt_den(rt_den)
  );

  always_comb begin
    div_go  = (state == S_PE_GO && !pe_neg) || state == S_RT_GO;
    div_num = (state == S_PE_GO) ? pe_num : rt_num;
    div_den = (state == S_PE_GO) ? pe_den : rt_den;
  end

  fsyn_divider #(.W(DW)) u_div (
    .i_clk(i_clk), .i_rst(i_rst), .i_go(div_go), .i_num(div_num),
    .i_den(div_den), .o_quo(div_q), .o_done(div_done)
  );

  always_comb begin
    cur_rate = div_q[FW-1:0];
    cur_dev  = (fout_r >= cur_rate) ? fout_r - cur_rate : cur_rate - fout_r;
  end

  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      state <= S_IDLE;  phase <= PH_LO;
      fin_r <= '0;  fout_r <= '0;  si <= '0;  md <= '0;  pe_c <= '0;
      cand_ok <= 1'b0;  lo_ok <= 1'b0;  lo_pe <= '0;  tune_hi <= '0;
      found <= 1'b0;  best_si <= '0;  best_md <= '0;  best_pe <= '0;
      best_rate <= '0;  best_dev <= '1;
      o_busy <= 1'b0;  o_done <= 1'b0;  o_nosol <= 1'b0;
      o_sdiv <= '0;  o_md <= '0;  o_pe <= '0;  o_rate <= '0;
    end else begin
      o_done <= 1'b0;
      case (state)
        S_IDLE: if (i_start) begin
          fin_r <= i_fin;  fout_r <= i_fout;
          si <= '0;  md <= '0;  pe_c <= '0;  phase <= PH_LO;
          found <= 1'b0;  best_dev <= '1;
          o_busy <= 1'b1;
          state <= (i_fin == '0 || i_fout == '0) ? S_DONE : S_PE_GO;
        end
        S_PE_GO: begin
          if (pe_neg) begin
            cand_ok <= 1'b0;
            state   <= S_NEXT;
          end else begin
            state <= S_PE_WAIT;
          end
        end
        S_PE_WAIT: if (div_done) begin
          pe_c <= div_q[14:0];
          if ((div_q >> PE_W) != '0) begin
            cand_ok <= 1'b0;
            state   <= S_NEXT;
          end else begin
            cand_ok <= 1'b1;
            state   <= S_RT_GO;
          end
        end
        S_RT_GO: state <= S_RT_WAIT;
        S_RT_WAIT: if (div_done) begin
          if (cur_dev < best_dev) begin
            best_dev <= cur_dev;  best_rate <= cur_rate;
            best_si <= si;  best_md <= md;  best_pe <= pe_c;
            found <= 1'b1;
          end
          state <= S_NEXT;
        end
        S_NEXT: begin
          if (found && best_dev == '0) begin
            state <= S_DONE;
          end else begin
            case (phase)
              PH_LO: begin
                lo_ok <= cand_ok;  lo_pe <= pe_c;
                md <= 5'(MD_TOP);  phase <= PH_HI;  state <= S_PE_GO;
              end
              PH_TUNE: begin
                if (pe_c == tune_hi) state <= S_DONE;
                else begin
                  pe_c  <= pe_c + 15'd1;
                  state <= S_RT_GO;
                end
              end
              default: begin
                if ((phase == PH_HI && lo_ok && cand_ok && lo_pe > pe_c) ||
                    (phase == PH_SWEEP && md == 5'd30)) begin
                  if (si == 4'(SDIV_LAST)) begin
                    if (!found) state <= S_DONE;
                    else begin
                      si      <= best_si;  md <= best_md;
                      pe_c    <= (best_pe >= 15'd2) ? best_pe - 15'd2 : 15'd0;
                      tune_hi <= (best_pe >= 15'd32765) ? 15'h7FFF : best_pe + 15'd2;
                      phase   <= PH_TUNE;
                      state   <= S_RT_GO;
                    end
                  end else begin
                    si <= si + 4'd1;  md <= '0;  phase <= PH_LO;  state <= S_PE_GO;
                  end
                end else begin
                  md    <= (phase == PH_HI) ? 5'd1 : md + 5'd1;
                  phase <= PH_SWEEP;
                  state <= S_PE_GO;
                end
              end
            endcase
          end
        end
        S_DONE: begin
          o_busy  <= 1'b0;
          o_done  <= 1'b1;
          o_nosol <= !found;
          o_sdiv  <= found ? best_si   : '0;
          o_md    <= found ? best_md   : '0;
          o_pe    <= found ? best_pe   : '0;
          o_rate  <= found ? best_rate : '0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fsyn_param_search_chk.sv
module fsyn_param_search_chk #(
  parameter int FW = 32
) (
  input logic          i_clk,
  input logic          i_rst,
  input logic          i_start,
  input logic          o_busy,
  input logic          o_done,
  input logic          o_nosol,
  input logic [3:0]    o_sdiv,
  input logic [4:0]    o_md,
  input logic [14:0]   o_pe,
  input logic [FW-1:0] o_rate
);
  p_done_pulse_r7: assert property (@(posedge i_clk) disable iff (i_rst)
    o_done |=> !o_done);

  p_busy_on_start_r7: assert property (@(posedge i_clk) disable iff (i_rst)
    (i_start && !o_busy) |=> o_busy);

  p_done_ends_busy_r7: assert property (@(posedge i_clk) disable iff (i_rst)
    o_done |-> (!o_busy && $past(o_busy)));

  p_hold_r8: assert property (@(posedge i_clk) disable iff (i_rst)
    !o_done |-> ($stable(o_rate) && $stable(o_pe) && $stable(o_md) &&
                 $stable(o_sdiv) && $stable(o_nosol)));

  p_nosol_zero_r6: assert property (@(posedge i_clk) disable iff (i_rst)
    (o_done && o_nosol) |-> (o_rate == '0 && o_pe == '0 && o_md == '0 && o_sdiv == '0));

  p_sdiv_range_r3: assert property (@(posedge i_clk) disable iff (i_rst)
    o_done |-> (o_sdiv <= 4'd8));
endmodule

bind fsyn_param_search fsyn_param_search_chk #(.FW(FW)) u_chk (
  .i_clk(i_clk), .i_rst(i_rst), .i_start(i_start), .o_busy(o_busy),
  .o_done(o_done), .o_nosol(o_nosol), .o_sdiv(o_sdiv), .o_md(o_md),
  .o_pe(o_pe), .o_rate(o_rate)
);

// File: tb/fsyn_param_search_bench.sv
module fsyn_param_search_bench;
  localparam int FW = 24;
  localparam int NV = 4;
  // stimulus: {fin, fout, expected no-solution flag}
  localparam logic [48:0] VEC [NV] = '{
    {24'd32000,    24'd1000,    1'b0},
    {24'd1000000,  24'd300000,  1'b0},
    {24'd12000000, 24'd7372800, 1'b0},
    {24'd5000000,  24'd77777,   1'b0}
  };

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [FW-1:0] fin = '0, fout = '0;
  logic          busy, done, nosol;
  logic [3:0]    sdiv;
  logic [4:0]    md;
  logic [14:0]   pe;
  logic [FW-1:0] rate;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  fsyn_param_search #(.FW(FW)) u_fsyn_param_search (
    .i_clk(clk), .i_rst(rst), .i_start(start), .i_fin(fin), .i_fout(fout),
    .o_busy(busy), .o_done(done), .o_nosol(nosol), .o_sdiv(sdiv),
    .o_md(md), .o_pe(pe), .o_rate(rate)
  );

  // independent model of the search
  longint unsigned m_dev, m_rate;
  int  m_si, m_md, m_pe;
  bit  m_found;

  function automatic longint unsigned rate_of(longint unsigned f, int s, int m, int p);
    return (f << 25) / (((longint'(32 + m) << 20) + (longint'(p) << 5)) << s);
  endfunction

  function automatic longint unsigned absd(longint unsigned a, longint unsigned b);
    return (a >= b) ? a - b : b - a;
  endfunction

  task automatic try_cand(longint unsigned f, longint unsigned o, int s, int m,
                          output bit ok, output int p);
    longint unsigned big, sub, q, r, d;
    big = f << 20;
    sub = (longint'(32 + m) * (o << s)) << 15;
    ok = 0;  p = 0;
    if (sub <= big) begin
      q = (big - sub) / (o << s);
      if (q <= 32767) begin
        ok = 1;  p = int'(q);
        r = rate_of(f, s, m, p);
        d = absd(o, r);
        if (d < m_dev) begin
          m_dev = d;  m_rate = r;  m_si = s;  m_md = m;  m_pe = p;  m_found = 1;
        end
      end
    end
  endtask

  task automatic model(longint unsigned f, longint unsigned o);
    bit ok0, ok1, okx;
    int p0, p1, px, lo, hi;
    longint unsigned r, d;
    m_dev = (64'd1 << FW) - 1;  m_found = 0;
    m_rate = 0;  m_si = 0;  m_md = 0;  m_pe = 0;
    if (f == 0 || o == 0) return;
    for (int s = 0; s <= 8; s++) begin
      try_cand(f, o, s, 0, ok0, p0);
      if (m_dev == 0) return;
      try_cand(f, o, s, 31, ok1, p1);
      if (m_dev == 0) return;
      if (!(ok0 && ok1 && p0 > p1)) begin
        for (int m = 1; m <= 30; m++) begin
          try_cand(f, o, s, m, okx, px);
          if (m_dev == 0) return;
        end
      end
    end
    if (!m_found) return;
    lo = (m_pe >= 2) ? m_pe - 2 : 0;
    hi = (m_pe >= 32765) ? 32767 : m_pe + 2;
    for (int p = lo; p <= hi; p++) begin
      r = rate_of(f, m_si, m_md, p);
      d = absd(o, r);
      if (d < m_dev) begin
        m_dev = d;  m_rate = r;  m_pe = p;
      end
    end
  endtask

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(logic [FW-1:0] f, logic [FW-1:0] o);
    @(negedge clk);
    fin = f;  fout = o;  start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic compare_all(string tag);
    model(longint'(fin), longint'(fout));
    check({tag, " R6 nosol"}, nosol, !m_found);
    check({tag, " R3 sdiv"},  sdiv,  m_si);
    check({tag, " R3 md"},    md,    m_md);
    check({tag, " R5 pe"},    pe,    m_pe);
    check({tag, " R2 rate"},  rate,  m_rate);
    if (m_found) check({tag, " R1 rate equation"}, rate, rate_of(fin, sdiv, md, pe));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [FW-1:0] h_rate;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 nosol", nosol, 0);
    check("R9 rate", rate, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      launch(VEC[i][48:25], VEC[i][24:1]);
      check("R7 busy after start", busy, 1);
      wait_done();
      check("R6 table nosol", nosol, VEC[i][0]);
      compare_all($sformatf("vec%0d", i));
      @(negedge clk);
      check("R7 done single cycle", done, 0);
    end

    // R4: exact hit must be reported with zero deviation
    launch(24'd32000, 24'd1000);
    wait_done();
    check("R4 exact rate", rate, 1000);
    check("R4 exact sdiv", sdiv, 5);

    // R7: start while busy is ignored
    launch(24'd1000000, 24'd300000);
    launch(24'd32000, 24'd1000);
    wait_done();
    fin = 24'd1000000;  fout = 24'd300000;
    compare_all("R7 start ignored");

    // R8: outputs hold after done
    h_rate = rate;
    repeat (20) @(negedge clk);
    check("R8 hold rate", rate, h_rate);

    // R6: target above reachable range, then zero reference
    launch(24'd1000, 24'd5000);
    wait_done();
    check("R6 unreachable nosol", nosol, 1);
    check("R6 unreachable rate", rate, 0);
    launch(24'd0, 24'd100);
    wait_done();
    check("R6 zero fin nosol", nosol, 1);
    check("R6 zero fin pe", pe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule